// File: doc/BRIEF.md
# Intervention Data Reply Sequencer

This block produces the data reply that a processor's system bus interface returns when an external intervention has hit a cache line held dirty and exclusive. Upstream logic hands it a one-cycle reply request carrying the request tag, a data-quality flag, the line's cache state, a burst-length choice and a flag that allows pauses between beats. The block then pulls 64-bit beats from a ready/valid source and places them on the bus.

Each reply opens with one empty issue cycle with the active-low valid strobe high. The issue cycle is allowed only when the interface owns the bus and the write-ready input was high two bus clocks before. If the interface does not own the bus, the block raises its bus request. It keeps the request up until the external agent answers with grant and release in the same cycle. Ownership then stays with the interface after the reply. It is given back only when the agent pulls it back while the sequencer is idle.

All block outputs are decoded from the sequencer state and the source handshake. The command field, data bus and strobe therefore show a beat in the same cycle the source offers it. The done pulse and the ownership flag are the only outputs that come from a register.

Top module: `intv_resp_seq`

## Requirements
- R1: The block leaves reset with the following outputs: sys_val_n=1, bus_req=0, is_master=0, done=0, req_ready=1, sys_cmd=0.
- R2: Every reply starts with exactly one issue cycle with sys_val_n=1. It is followed directly by the first data beat. In the issue cycle is_master=1 holds.
- R3: A reply carries exactly 8 data beats when req_long=0 and exactly 16 when req_long=1. Source words are placed on sys_ad in the order the source offers them.
- R4: A data beat is a cycle with sys_val_n=0. On every beat, sys_cmd[11]=1 and sys_cmd[0]=1. sys_cmd[10:8] carries the request tag and sys_cmd[7:6]=0. sys_cmd[5] carries the quality flag and sys_cmd[2:1] the cache state. sys_cmd and sys_ad are 0 outside beats.
- R5: sys_cmd[4:3] is 2'b00 (reply data) on every beat but the final one. The final beat carries 2'b01 (reply last data).
- R6: With req_gap_ok=1, a cycle inside the burst in which the source offers no word has sys_val_n=1 and uses up no beat. With req_gap_ok=0, the beats follow one another on consecutive cycles.
- R7: The issue cycle happens only if wr_rdy was 1 exactly two cycles earlier. While wr_rdy stays 0, the reply is held back.
- R8: When not master, the block raises bus_req from the cycle after the request is accepted. bus_req stays up until bus_gnt and bus_rel are both 1 in one cycle. In the next cycle is_master=1 and bus_req=0. Grant without release does not confer ownership.
- R9: When the block is already master, bus_req stays 0. With wr_rdy held high, the issue cycle is the first cycle after acceptance and the first beat comes in the cycle after that.
- R10: done is 1 for exactly the one cycle after the final beat, and req_ready is 1 in that cycle.
- R11: bus_take_back clears is_master only while the sequencer is idle. During a reply it has no effect.
- R12: req_valid is ignored while a reply is in progress. The fields of the reply being sent stay unchanged, and no second reply follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Reply request, accepted when req_ready=1 |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_num | input | 3 | Request tag of the intervention |
| req_quality | input | 1 | Data quality flag |
| req_blk_state | input | 2 | Cache state of the line |
| req_long | input | 1 | 1 selects 16 beats, 0 selects 8 |
| req_gap_ok | input | 1 | 1 allows pauses between beats |
| src_valid | input | 1 | Source offers a data word |
| src_ready | output | 1 | Block accepts a word this cycle if offered |
| src_data | input | 64 | Source data word |
| wr_rdy | input | 1 | Write-ready from the external agent (active high) |
| bus_gnt | input | 1 | Bus grant from the external agent |
| bus_rel | input | 1 | Bus release from the external agent |
| bus_take_back | input | 1 | Agent reclaims bus ownership |
| bus_req | output | 1 | Bus ownership request |
| is_master | output | 1 | Interface owns the bus |
| sys_cmd | output | 12 | Command field of the beat |
| sys_ad | output | 64 | Data bus |
| sys_val_n | output | 1 | Active-low beat strobe |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The assertions check several rules in every cycle. They cover the ownership handshake and the rule that ownership is kept through a reply. They check the two-cycle write-ready rule at each issue, and that every first beat follows an issue cycle held while master. They also cover back-to-back beats without the gap flag, the beat-count bound, and the done pulse after each last-data beat. Only the bench scenarios can show the rest. These are the full beat-by-beat contents of the command field and data bus, and the total beat count for each length. They also include pauses taken from a stalling source in gap mode, the exact issue latency after write-ready rises, and that requests arriving mid-reply are ignored.

// File: rtl/intv_resp_pkg.sv
package intv_resp_pkg;

  localparam int CMD_W = 12;

  localparam logic [1:0] TYPE_DATA = 2'b00;
  localparam logic [1:0] TYPE_LAST = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND,
    ST_DATA
  } seq_state_e;

  typedef struct packed {
    logic [2:0] num;
    logic       quality;
    logic [1:0] blk_state;
    logic       long_burst;
    logic       gap_ok;
  } resp_req_t;

  // Command word of one data beat; field positions are decoded by the bus peer.
  function automatic logic [CMD_W-1:0] beat_cmd(input resp_req_t r, input logic last);
    logic [CMD_W-1:0] c;
    c        = '0;
    c[11]    = 1'b1;
    c[10:8]  = r.num;
    c[5]     = r.quality;
    c[4:3]   = last ? TYPE_LAST : TYPE_DATA;
    c[2:1]   = r.blk_state;
    c[0]     = 1'b1;
    return c;
  endfunction

  // Index of the final beat for a given length choice.
  function automatic int unsigned final_index(input logic long_burst,
                                              input int unsigned short_beats,
                                              input int unsigned long_beats);
    return long_burst ? long_beats - 1 : short_beats - 1;
  endfunction

endpackage

// File: rtl/intv_wr_history.sv
module intv_wr_history #(
  parameter int unsigned LAG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_rdy,
  output logic seen_lag
);
  logic [LAG-1:0] hist;

  generate
    if (LAG == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= wr_rdy;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[LAG-2:0], wr_rdy};
      end
    end
  endgenerate

  assign seen_lag = hist[LAG-1];
endmodule

// File: rtl/intv_mastership.sv
module intv_mastership (
  input  logic clk,
  input  logic rst_n,
  input  logic want_bus,
  input  logic busy,
  input  logic bus_gnt,
  input  logic bus_rel,
  input  logic bus_take_back,
  output logic bus_req,
  output logic is_master
);
  logic won_bus;
  logic lost_bus;

  assign bus_req  = want_bus && !is_master;
  assign won_bus  = bus_req && bus_gnt && bus_rel;
  assign lost_bus = bus_take_back && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)        is_master <= 1'b0;
    else if (won_bus)  is_master <= 1'b1;
    else if (lost_bus) is_master <= 1'b0;
  end

  a_r8_grant_confers: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_rel) |=> (is_master && !bus_req));

  a_r8_wait_full_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(bus_gnt && bus_rel)) |=> !is_master);

  a_r11_keep_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_master) |=> is_master);
endmodule

// File: rtl/intv_beat_counter.sv
module intv_beat_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             at_last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == limit);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt <= limit));
endmodule

// File: rtl/intv_resp_seq.sv
module intv_resp_seq
  import intv_resp_pkg::*;
#(
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned SHORT_BEATS = 8,
  parameter int unsigned LONG_BEATS  = 16,
  parameter int unsigned WR_LAG      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_num,
  input  logic              req_quality,
  input  logic [1:0]        req_blk_state,
  input  logic              req_long,
  input  logic              req_gap_ok,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              wr_rdy,
  input  logic              bus_gnt,
  input  logic              bus_rel,
  input  logic              bus_take_back,
  output logic              bus_req,
  output logic              is_master,
  output logic [CMD_W-1:0]  sys_cmd,
  output logic [DATA_W-1:0] sys_ad,
  output logic              sys_val_n,
  output logic              done
);
  localparam int unsigned CNT_W = $clog2(LONG_BEATS);

  seq_state_e       state;
  resp_req_t        req_q;
  logic             wr_seen;
  logic             issue;
  logic             beat;
  logic             last_beat;
  logic             at_last;
  logic             busy;
  logic [CNT_W-1:0] limit;

  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE);
  assign src_ready = (state == ST_DATA);
  assign issue     = (state == ST_PEND) && is_master && wr_seen && src_valid;
  assign beat      = (state == ST_DATA) && src_valid;
  assign last_beat = beat && at_last;
  assign limit     = CNT_W'(final_index(req_q.long_burst, SHORT_BEATS, LONG_BEATS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      req_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_beat;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          req_q <= '{num: req_num, quality: req_quality, blk_state: req_blk_state,
                     long_burst: req_long, gap_ok: req_gap_ok};
          state <= ST_PEND;
        end
        ST_PEND: if (issue) state <= ST_DATA;
        ST_DATA: if (last_beat) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  intv_wr_history #(.LAG(WR_LAG)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_rdy   (wr_rdy),
    .seen_lag (wr_seen)
  );

  intv_mastership u_master (
    .clk           (clk),
    .rst_n         (rst_n),
    .want_bus      (state == ST_PEND),
    .busy          (busy),
    .bus_gnt       (bus_gnt),
    .bus_rel       (bus_rel),
    .bus_take_back (bus_take_back),
    .bus_req       (bus_req),
    .is_master     (is_master)
  );

  intv_beat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (issue),
    .step    (beat),
    .limit   (limit),
    .at_last (at_last)
  );

  assign sys_val_n = !beat;
  assign sys_cmd   = beat ? beat_cmd(req_q, at_last) : '0;
  assign sys_ad    = beat ? src_data : '0;

  // R2: the first beat is preceded by an empty cycle held while master
  a_r2_issue_before_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_PEND) |-> ($past(sys_val_n) && $past(is_master)));

  a_r7_wr_two_back: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> $past(wr_rdy, WR_LAG));

  a_r6_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && !req_q.gap_ok) |-> !sys_val_n);

  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!sys_val_n && sys_cmd[4:3] == TYPE_LAST));
endmodule

// File: tb/intv_resp_seq_tb.sv
module intv_resp_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_quality, req_long, req_gap_ok;
  logic [2:0]  req_num;
  logic [1:0]  req_blk_state;
  logic        src_valid, src_ready;
  logic [63:0] src_data;
  logic        wr_rdy, bus_gnt, bus_rel, bus_take_back;
  logic        bus_req, is_master, sys_val_n, done;
  logic [11:0] sys_cmd;
  logic [63:0] sys_ad;

  always #10 clk = ~clk;

  intv_resp_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_num(req_num), .req_quality(req_quality), .req_blk_state(req_blk_state),
    .req_long(req_long), .req_gap_ok(req_gap_ok), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data), .wr_rdy(wr_rdy), .bus_gnt(bus_gnt),
    .bus_rel(bus_rel), .bus_take_back(bus_take_back), .bus_req(bus_req),
    .is_master(is_master), .sys_cmd(sys_cmd), .sys_ad(sys_ad), .sys_val_n(sys_val_n),
    .done(done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [75:0] act, input logic [75:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Source model: word i is a pattern the bench can recompute
  function automatic logic [63:0] src_word(input int unsigned i);
    return {16'hA5C3, i[15:0], (i * 32'h01010101) ^ 32'h5A5A5A5A};
  endfunction

  int unsigned src_idx = 0;
  logic src_on = 1'b0, src_holes = 1'b0, hole_phase = 1'b0;
  assign src_valid = src_on && (!src_holes || hole_phase || !src_ready);
  assign src_data  = src_word(src_idx);
  always @(posedge clk) begin
    if (src_valid && src_ready) src_idx <= src_idx + 1;
    hole_phase <= ~hole_phase;
  end

  // Scoreboard
  logic [75:0] exp_q[$];
  bit   in_burst = 0, expect_done = 0, done_seen = 0, cur_gap_ok = 0;
  logic prev_valn = 1'b1, prev_master = 1'b0;
  logic [2:0] wh = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (expect_done) begin
        chk(done && req_ready, "R10 done after last beat", {74'd0, done, req_ready}, 76'd3);
        expect_done = 0;
        done_seen   = 1;
      end else if (done) begin
        chk(1'b0, "R10 stray done", 76'd1, 76'd0);
      end
      if (is_master && bus_req) chk(1'b0, "R9 request while master", 76'd1, 76'd0);
      if (in_burst && sys_val_n && !cur_gap_ok)
        chk(1'b0, "R6 gap without permission", 76'd1, 76'd0);
      if (!sys_val_n) begin
        if (!in_burst) begin
          chk(prev_valn && prev_master, "R2 issue cycle empty and master",
              {74'd0, prev_valn, prev_master}, 76'd3);
          chk(wh[2], "R7 write-ready two cycles before issue", {75'd0, wh[2]}, 76'd1);
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 extra beat", {sys_cmd, sys_ad}, 76'd0);
        end else begin
          logic [75:0] e;
          e = exp_q.pop_front();
          chk(sys_cmd == e[75:64], "R4 R5 command field", {64'd0, sys_cmd}, {64'd0, e[75:64]});
          chk(sys_ad == e[63:0], "R3 R4 data word", {12'd0, sys_ad}, {12'd0, e[63:0]});
        end
        if (sys_cmd[4:3] == 2'b01) begin in_burst = 0; expect_done = 1; end
        else in_burst = 1;
      end
      wh          = {wh[1:0], wr_rdy};
      prev_valn   = sys_val_n;
      prev_master = is_master;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [2:0] num, input logic q, input logic [1:0] st,
                      input logic lng, input logic gap, input logic holes);
    int n;
    n = lng ? 16 : 8;
    cur_gap_ok = gap;
    src_holes  = holes;
    for (int i = 0; i < n; i++) begin
      logic [11:0] c;
      c = {1'b1, num, 2'b00, q, (i == n - 1) ? 2'b01 : 2'b00, st, 1'b1};
      exp_q.push_back({c, src_word(src_idx + i)});
    end
    req_num = num; req_quality = q; req_blk_state = st; req_long = lng; req_gap_ok = gap;
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done_seen && k < 300) begin @(negedge clk); k++; end
    chk(done_seen, "R10 reply completes", {75'd0, done_seen}, 76'd1);
    chk(exp_q.size() == 0, "R3 beat count", 76'(exp_q.size()), 76'd0);
    exp_q.delete();
    done_seen = 0;
    @(negedge clk);
    tick();
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_num = 0; req_quality = 0; req_blk_state = 0;
    req_long = 0; req_gap_ok = 0; wr_rdy = 1; bus_gnt = 0; bus_rel = 0; bus_take_back = 0;
    repeat (3) tick();
    @(negedge clk);
    chk(sys_val_n && !bus_req && !is_master && !done && req_ready && sys_cmd == 0, "R1 reset state",
        {70'd0, sys_val_n, bus_req, is_master, done, req_ready, sys_cmd == 0}, 76'b100011);
    tick();
    rst_n = 1; src_on = 1;
    repeat (3) tick();

    // Ownership handshake, short burst
    send(3'd5, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    chk(bus_req && !is_master && sys_val_n, "R8 request raised", {73'd0, bus_req, is_master, sys_val_n}, 76'b101);
    tick(); bus_gnt = 1;
    tick(); tick();
    @(negedge clk);
    chk(!is_master && bus_req, "R8 grant alone insufficient", {74'd0, is_master, bus_req}, 76'b01);
    tick(); bus_rel = 1;
    tick(); bus_gnt = 0; bus_rel = 0;
    @(negedge clk);
    chk(is_master && !bus_req, "R8 ownership taken", {74'd0, is_master, bus_req}, 76'b10);
    wait_done();
    chk(is_master, "R11 stays master after reply", {75'd0, is_master}, 76'd1);

    // Already master, long burst, immediate issue
    send(3'd2, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk(sys_val_n && !bus_req, "R9 issue cycle, no request", {74'd0, sys_val_n, bus_req}, 76'b10);
    @(negedge clk);
    chk(!sys_val_n, "R9 first beat right after issue", {75'd0, sys_val_n}, 76'd0);
    wait_done();

    // Gap mode with a stalling source
    send(3'd7, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1);
    wait_done();
    src_holes = 0;

    // Write-ready gating
    wr_rdy = 0;
    repeat (3) tick();
    send(3'd3, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(sys_val_n, "R7 held while write-ready low", {75'd0, sys_val_n}, 76'd1);
    end
    tick(); wr_rdy = 1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      chk(sys_val_n == (i < 4), "R7 issue two cycles after write-ready",
          {75'd0, sys_val_n}, {75'd0, i < 4});
    end
    wait_done();

    // Take-back during a reply and while idle
    send(3'd1, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
    while (sys_val_n) @(negedge clk);
    tick(); bus_take_back = 1;
    tick(); bus_take_back = 0;
    @(negedge clk);
    chk(is_master, "R11 take-back ignored while busy", {75'd0, is_master}, 76'd1);
    wait_done();
    bus_take_back = 1;
    tick(); bus_take_back = 0;
    @(negedge clk);
    chk(!is_master, "R11 take-back while idle", {75'd0, is_master}, 76'd0);
    tick();

    // New request while busy is ignored
    bus_gnt = 1; bus_rel = 1;
    send(3'd6, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
    while (sys_val_n) @(negedge clk);
    tick();
    req_num = 3'd1; req_quality = 1'b1; req_blk_state = 2'b11; req_long = 1'b1; req_valid = 1'b1;
    tick(); req_valid = 1'b0;
    bus_gnt = 0; bus_rel = 0;
    wait_done();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(sys_val_n && req_ready && !bus_req, "R12 no second reply",
          {73'd0, sys_val_n, req_ready, bus_req}, 76'b110);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule